// File: doc/BRIEF.md
# Nonvolatile Memory Write Guard

This block stands between the command decoder of a serial memory and its 8K x 8 storage array. For every write request it decides whether the write may go ahead. It keeps a small protection register that is mapped at the very top of a 16-bit address space. That register holds three things: a volatile write-enable latch, a two-bit lock field that protects an upper part of the array, and an enable bit. When that enable bit is set and the protect pin is high, both the locked region and the register itself become permanent.

Each write request is judged on the clock edge where it is sampled. One cycle later the block raises a permit pulse for an array write that it accepts, or a blocked pulse for a write that it refuses. The register contents are always visible on a read port. The lock field and the enable bit model nonvolatile cells, so reset does not change them. Reset clears only the write-enable latch.

Top module: `wpg_guard`

## Requirements
- R1: After reset, `wr_permit` and `wr_blocked` are 0 and the latch (`wpr_q[1]`) is 0. Bits 6, 5, 2 and 0 of `wpr_q` always read 0.
- R2: While the latch is 0, every write to an array address (0000h–1FFFh) is refused. A refused write gives a blocked pulse, no permit pulse, and leaves the register unchanged.
- R3: A write to FFFFh while the latch is 0 only loads the latch from data bit 1. Bits 7 and 4:3 stay unchanged, and neither pulse is raised.
- R4: A write to FFFFh while the latch is 1 and the hardware lock is not active loads the lock field from data bits 4:3 and the enable bit from data bit 7. It also clears the latch and raises neither pulse.
- R5: Lock field encodings: 00 locks nothing, 01 locks 1800h–1FFFh, 10 locks 1000h–1FFFh, and 11 locks 0000h–1FFFh. An array write to a locked address is refused even while the latch is 1.
- R6: An array write with the latch at 1 to an unlocked address raises `wr_permit` for exactly one cycle, in the cycle after the request. It also clears the latch.
- R7: The hardware lock is active when `wpr_q[7]` is 1 and `wp_pin` is 1. While it is active, a write to FFFFh with the latch at 1 is refused and leaves `wpr_q` unchanged.
- R8: While `wp_pin` is 0, the enable bit has no effect. The register can then be rewritten under the latch alone.
- R9: Writes to 2000h–FFFEh are always refused.
- R10: `wr_permit` and `wr_blocked` are never high together. Each one is high only in the cycle after a sampled request.
- R11: Bits 7 and 4:3 keep their values across reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| wr_req | input | 1 | Write strobe, sampled on the rising edge |
| wr_addr | input | 16 | Write address |
| wr_data | input | 8 | Write data, used for register writes |
| wp_pin | input | 1 | Write-protect pin, active high |
| wr_permit | output | 1 | One-cycle pulse: the array write may proceed |
| wr_blocked | output | 1 | One-cycle pulse: the write was refused |
| wpr_q | output | 8 | Protection register read value |

## Verification
The hardest situation to reach is a refused register write under the hardware lock. Getting there takes a fixed order of events: the latch must be set, the enable bit must then be programmed, the latch must be set again, and the pin must be high at the moment of the final write. The stimulus reaches this state twice. A directed sequence walks through those steps in order. A long stream of random writes then biases about a quarter of its requests toward FFFFh and draws the pin afresh on each write, so that chains of latch-set, lock and release occur many times. Resets placed in the middle of the run confirm that the locked state survives a power cycle.

// File: rtl/wpg_pkg.sv
package wpg_pkg;
  localparam int WEL_BIT  = 1;
  localparam int BP_LO    = 3;
  localparam int WPEN_BIT = 7;

  typedef enum logic [1:0] {
    ACC_ARRAY = 2'd0,
    ACC_REG   = 2'd1,
    ACC_VOID  = 2'd2
  } acc_e;

  typedef struct packed {
    logic       wpen;
    logic [1:0] bp;
    logic       wel;
  } wpr_t;
endpackage

// File: rtl/wpg_addr_dec.sv
module wpg_addr_dec
  import wpg_pkg::*;
#(
  parameter int AW     = 13,
  parameter int BUS_AW = 16
) (
  input  logic [BUS_AW-1:0] addr,
  input  logic [1:0]        bp,
  output acc_e              kind,
  output logic              locked
);
  localparam int HI_W = BUS_AW - AW;

  logic in_array;
  assign in_array = (addr[BUS_AW-1:AW] == {HI_W{1'b0}});

  always_comb begin
    if (&addr)         kind = ACC_REG;
    else if (in_array) kind = ACC_ARRAY;
    else               kind = ACC_VOID;
  end

  // lock region always grows downward from the top of the array
  always_comb begin
    unique case (bp)
      2'b00:   locked = 1'b0;
      2'b01:   locked = &addr[AW-1:AW-2];
      2'b10:   locked = addr[AW-1];
      default: locked = 1'b1;
    endcase
  end
endmodule

// File: rtl/wpg_policy.sv
module wpg_policy
  import wpg_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          req,
  input  acc_e          kind,
  input  logic          locked,
  input  wpr_t          cur,
  input  logic          wp_pin,
  input  logic [DW-1:0] data,
  output logic          permit_d,
  output logic          block_d,
  output logic          latch_ld,
  output logic          nv_ld,
  output wpr_t          nv_val
);
  logic hw_lock;
  assign hw_lock = cur.wpen & wp_pin;

  always_comb begin
    permit_d = 1'b0;
    block_d  = 1'b0;
    latch_ld = 1'b0;
    nv_ld    = 1'b0;
    nv_val   = '{wpen: data[WPEN_BIT], bp: data[BP_LO+1:BP_LO], wel: data[WEL_BIT]};
    if (req) begin
      unique case (kind)
        ACC_ARRAY: begin
          permit_d = cur.wel & ~locked;
          block_d  = ~(cur.wel & ~locked);
        end
        ACC_REG: begin
          if (!cur.wel)     latch_ld = 1'b1;
          else if (hw_lock) block_d  = 1'b1;
          else              nv_ld    = 1'b1;
        end
        default: block_d = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/wpg_state.sv
module wpg_state
  import wpg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic permit_d,
  input  logic block_d,
  input  logic latch_ld,
  input  logic nv_ld,
  input  wpr_t nv_val,
  output wpr_t cur,
  output logic permit_q,
  output logic block_q
);
  logic       wel_q, wel_d;
  logic       wpen_q;
  logic [1:0] bp_q;

  always_comb begin
    wel_d = wel_q;
    if (nv_ld || permit_d) wel_d = 1'b0;
    else if (latch_ld)     wel_d = nv_val.wel;
  end

  // volatile state: cleared by power-on reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel_q    <= 1'b0;
      permit_q <= 1'b0;
      block_q  <= 1'b0;
    end else begin
      wel_q    <= wel_d;
      permit_q <= permit_d;
      block_q  <= block_d;
    end
  end

  // nonvolatile cells: untouched by reset, written only on enable
  always_ff @(posedge clk) begin
    if (nv_ld) begin
      wpen_q <= nv_val.wpen;
      bp_q   <= nv_val.bp;
    end
  end

  assign cur = '{wpen: wpen_q, bp: bp_q, wel: wel_q};
endmodule

// File: rtl/wpg_guard.sv
module wpg_guard
  import wpg_pkg::*;
#(
  parameter int AW     = 13,
  parameter int BUS_AW = 16,
  parameter int DW     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_req,
  input  logic [BUS_AW-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic              wp_pin,
  output logic              wr_permit,
  output logic              wr_blocked,
  output logic [DW-1:0]     wpr_q
);
  acc_e kind;
  logic locked, permit_d, block_d, latch_ld, nv_ld;
  wpr_t cur, nv_val;

  wpg_addr_dec #(.AW(AW), .BUS_AW(BUS_AW)) dec_i (
    .addr(wr_addr), .bp(cur.bp), .kind(kind), .locked(locked)
  );

  wpg_policy #(.DW(DW)) pol_i (
    .req(wr_req), .kind(kind), .locked(locked), .cur(cur), .wp_pin(wp_pin),
    .data(wr_data), .permit_d(permit_d), .block_d(block_d),
    .latch_ld(latch_ld), .nv_ld(nv_ld), .nv_val(nv_val)
  );

  wpg_state st_i (
    .clk(clk), .rst_n(rst_n), .permit_d(permit_d), .block_d(block_d),
    .latch_ld(latch_ld), .nv_ld(nv_ld), .nv_val(nv_val), .cur(cur),
    .permit_q(wr_permit), .block_q(wr_blocked)
  );

  always_comb begin
    wpr_q                   = '0;
    wpr_q[WEL_BIT]          = cur.wel;
    wpr_q[BP_LO+1:BP_LO]    = cur.bp;
    wpr_q[WPEN_BIT]         = cur.wpen;
  end
endmodule

// File: rtl/wpg_guard_chk.sv
module wpg_guard_chk #(
  parameter int AW     = 13,
  parameter int BUS_AW = 16,
  parameter int DW     = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_req,
  input logic [BUS_AW-1:0] wr_addr,
  input logic              wp_pin,
  input logic              wr_permit,
  input logic              wr_blocked,
  input logic [DW-1:0]     wpr_q
);
  logic is_arr, is_reg, is_void;
  assign is_arr  = (wr_addr < BUS_AW'(1 << AW));
  assign is_reg  = (&wr_addr);
  assign is_void = !is_arr && !is_reg;

  // R2
  wel_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req && is_arr && !wpr_q[1] |=> wr_blocked && !wr_permit);

  // R6
  wel_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_permit |-> !wpr_q[1]);

  // R7
  hw_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req && is_reg && wpr_q[1] && wpr_q[7] && wp_pin |=> wr_blocked && $stable(wpr_q));

  // R9
  void_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req && is_void |=> wr_blocked);

  // R10
  excl_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_permit && wr_blocked));

  // R10
  pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_req |=> !wr_permit && !wr_blocked);
endmodule

bind wpg_guard wpg_guard_chk #(.AW(AW), .BUS_AW(BUS_AW), .DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_addr(wr_addr), .wp_pin(wp_pin),
  .wr_permit(wr_permit), .wr_blocked(wr_blocked), .wpr_q(wpr_q)
);

// File: tb/wpg_guard_tb.sv
module wpg_guard_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n, wr_req, wp_pin;
  logic [15:0] wr_addr;
  logic [7:0]  wr_data;
  logic        wr_permit, wr_blocked;
  logic [7:0]  wpr_q;

  int tests = 0, fails = 0;
  bit m_wel, m_wpen;
  bit [1:0] m_bp;

  wpg_guard dut_i (
    .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_addr(wr_addr),
    .wr_data(wr_data), .wp_pin(wp_pin), .wr_permit(wr_permit),
    .wr_blocked(wr_blocked), .wpr_q(wpr_q)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 150000);
    fails++; tests++;
    $display("FAIL watchdog: run did not finish, act=hung exp=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  function automatic bit in_lock(bit [1:0] bp, bit [15:0] a);
    case (bp)
      2'b00: return 1'b0;
      2'b01: return a[12:11] == 2'b11;
      2'b10: return a[12];
      default: return 1'b1;
    endcase
  endfunction

  function automatic bit [7:0] model_reg();
    return {m_wpen, 2'b00, m_bp, 1'b0, m_wel, 1'b0};
  endfunction

  task automatic check(string req, bit [31:0] act, bit [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic do_write(bit [15:0] a, bit [7:0] d, bit pin, string tag);
    bit ep, eb;
    ep = 0; eb = 0;
    wr_addr = a; wr_data = d; wp_pin = pin; wr_req = 1'b1;
    if (a == 16'hFFFF) begin
      if (!m_wel) m_wel = d[1];
      else if (m_wpen && pin) eb = 1;
      else begin m_wpen = d[7]; m_bp = d[4:3]; m_wel = 0; end
    end else if (a < 16'h2000) begin
      if (m_wel && !in_lock(m_bp, a)) begin ep = 1; m_wel = 0; end
      else eb = 1;
    end else eb = 1;
    @(posedge clk); @(negedge clk);
    wr_req = 1'b0;
    check({tag, " permit"}, wr_permit, ep);
    check({tag, " blocked"}, wr_blocked, eb);
    check({tag, " reg"}, wpr_q, model_reg());
    @(negedge clk);
    check("R10 pulse width", {wr_permit, wr_blocked}, 0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; @(negedge clk); rst_n = 1'b1; @(negedge clk);
    m_wel = 0;
  endtask

  initial begin
    wr_req = 0; wr_addr = 0; wr_data = 0; wp_pin = 0; rst_n = 0;
    void'($urandom(32'd4242));
    @(negedge clk); @(negedge clk); rst_n = 1; @(negedge clk);
    check("R1 reset pulses", {wr_permit, wr_blocked}, 0);
    check("R1 reset latch", wpr_q[1], 0);
    check("R1 unused bits", {wpr_q[6:5], wpr_q[2], wpr_q[0]}, 0);

    // make the nonvolatile contents defined
    m_wel = 0;
    do_write(16'hFFFF, 8'h02, 0, "R3 latch set");
    do_write(16'hFFFF, 8'h00, 0, "R4 clear nv");
    m_wpen = 0; m_bp = 0;
    check("R4 cleared reg", wpr_q, 8'h00);

    do_write(16'h0100, 8'h00, 0, "R2 no latch");
    do_write(16'hFFFF, 8'h9A, 0, "R3 latch only");
    do_write(16'h0100, 8'h00, 0, "R6 permit");
    do_write(16'h0100, 8'h00, 0, "R6 latch cleared");
    // lock 01: top quarter
    do_write(16'hFFFF, 8'h02, 0, "R3 set");
    do_write(16'hFFFF, 8'h08, 0, "R4 bp01");
    do_write(16'hFFFF, 8'h02, 0, "R3 set");
    do_write(16'h1800, 8'h00, 0, "R5 bp01 locked");
    do_write(16'h17FF, 8'h00, 0, "R5 bp01 edge free");
    // lock 10, then 11
    do_write(16'hFFFF, 8'h02, 0, "R3 set");
    do_write(16'hFFFF, 8'h10, 0, "R4 bp10");
    do_write(16'hFFFF, 8'h02, 0, "R3 set");
    do_write(16'h1000, 8'h00, 0, "R5 bp10 locked");
    do_write(16'h0FFF, 8'h00, 0, "R5 bp10 edge free");
    do_write(16'hFFFF, 8'h02, 0, "R3 set");
    do_write(16'hFFFF, 8'h98, 0, "R4 bp11 wpen");
    do_write(16'hFFFF, 8'h02, 1, "R3 set");
    do_write(16'h0000, 8'h00, 1, "R5 bp11 locked");
    do_write(16'hFFFF, 8'h00, 1, "R7 hw freeze");
    do_write(16'h2000, 8'h00, 1, "R9 void lo");
    do_write(16'hFFFE, 8'h00, 1, "R9 void hi");
    do_reset();
    check("R11 nv kept", wpr_q, 8'h98);
    do_write(16'hFFFF, 8'h02, 0, "R3 set");
    do_write(16'hFFFF, 8'h00, 0, "R8 pin low unlock");

    for (int i = 0; i < 3000; i++) begin
      bit [15:0] a;
      int sel;
      sel = $urandom_range(0, 99);
      if (sel < 25) a = 16'hFFFF;
      else if (sel < 35) a = 16'h2000 + 16'($urandom_range(0, 16'hDFFE));
      else a = 16'($urandom_range(0, 16'h1FFF));
      if ($urandom_range(0, 199) == 0) begin
        do_reset();
        check("R11 nv across reset", wpr_q, model_reg());
      end
      do_write(a, 8'($urandom), 1'($urandom), "R5 random");
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule